// File: doc/BRIEF.md
# Receive Descriptor Ring Index Tracker

This block keeps the indices of a circular ring of receive buffer descriptors that host software and a receive DMA engine share. Software posts a write index through a register port. It names the descriptor one past the last buffer it has handed over. The block holds a fill index that points at the currently open buffer.

Frame-done strobes from the data path add bytes to the open buffer. The buffer closes when its byte count reaches the configured buffer size, or when a programmable idle timeout expires after its last frame. On each close the block publishes the index of the descriptor just closed in a status word. It then advances the fill index and, if the interrupt destination selects the host, pulses an interrupt request.

The ring depth is a power of two chosen by a configuration field. The ring counts as full whenever the fill index equals the write index, so software can have at most depth minus one buffers outstanding. Moving data and fetching descriptors belong to other blocks.

Top module: `rx_ring_tracker`

## Requirements
- R1: After a synchronous active-low reset the write index and fill index are 0, `status_word` is 0, `irq` is 0, `wr_idx_err` is 0 and `buf_avail` is 0.
- R2: The ring depth is 2^N with N taken from `cfg_ring_log2`. Values below 5 act as 5 and values above 12 act as 12. All indices wrap modulo the depth.
- R3: A write with `sw_wr_en` whose `sw_wr_idx[2:0]` is zero is accepted. The write index becomes `sw_wr_idx` modulo the depth.
- R4: A write whose `sw_wr_idx[2:0]` is non-zero leaves the write index unchanged and sets `wr_idx_err`, which stays set until reset.
- R5: `buf_avail` is 1 exactly when the fill index differs from the write index. A `frame_done` while `buf_avail` is 0 is dropped and changes neither `status_word` nor `irq`.
- R6: An accepted frame adds `frame_len` bytes to the open buffer. The buffer closes on the frame that brings its total to at least (`cfg_buf_size`+1) × UNIT_BYTES, and that frame is part of the buffer.
- R7: When a buffer closes, `status_word[11:0]` takes the index of the closed descriptor and bits 31:12 are 0. The fill index advances by one modulo the depth. Both updates are visible in the cycle after the clock edge that sampled the closing event.
- R8: With `cfg_timeout` = T ≠ 0, a buffer that holds at least one frame closes on the clock edge T × TICK_DIV + 1 cycles after the edge that took its last frame. T = 0 disables the timeout.
- R9: Every accepted frame that does not close the buffer restarts the timeout from zero.
- R10: Each close drives `irq` high for that one cycle when `cfg_irq_dest` is 2'b01. With any other value a close leaves `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ring_log2 | input | 4 | Ring depth exponent N (clamped to 5..12) |
| cfg_buf_size | input | 2 | Buffer size code; capacity (code+1) × UNIT_BYTES |
| cfg_timeout | input | 8 | Buffer-close timeout in ticks; 0 disables |
| cfg_irq_dest | input | 2 | 2'b01 routes closes to `irq`, other values suppress it |
| sw_wr_en | input | 1 | Software write-index strobe |
| sw_wr_idx | input | 12 | Software write index (must be a multiple of 8) |
| frame_done | input | 1 | One frame has landed in the open buffer |
| frame_len | input | 14 | Byte length of that frame |
| buf_avail | output | 1 | An open buffer is available to the data path |
| status_word | output | 32 | Index of latest closed descriptor in bits 11:0 |
| irq | output | 1 | One-cycle interrupt request per close |
| wr_idx_err | output | 1 | Sticky flag for a misaligned write index |

## Verification
The bench builds the block with TICK_DIV = 4 and UNIT_BYTES = 64. With those values a 3-tick timeout lands exactly 13 cycles after a frame, and a buffer fills with frames of a few dozen bytes. That brings the exact close cycle, the timer restart and the 128-byte size code within a short run. A 32-entry ring lets the test wrap the fill index past the top and back to zero, and reach the full condition after each batch of eight. A depth exponent below the legal range checks the clamp through the masked write index.

// File: rtl/rxr_pkg.sv
// Package: shared constants and helpers for the receive ring tracker.
// Assumes indices are 12 bits wide and the ring exponent lies in 5..12.
package rxr_pkg;
    localparam int IDX_W    = 12;
    localparam int LOG2_MIN = 5;
    localparam int LOG2_MAX = 12;

    // Index mask for a ring of 2^N entries, with N clamped to the legal range.
    function automatic logic [IDX_W-1:0] ring_mask(input logic [3:0] n);
        int k;
        k = int'(n);
        if (k < LOG2_MIN) k = LOG2_MIN;
        if (k > LOG2_MAX) k = LOG2_MAX;
        return IDX_W'((1 << k) - 1);
    endfunction
endpackage

// File: rtl/rxr_index_ctl.sv
// Module: write-index register and fill-index counter.
// It accepts software write indices that are multiples of 8, flags the
// others, and advances the fill index on each buffer close. Assumes
// close is only raised while a buffer is available.
module rxr_index_ctl
    import rxr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] mask,
    input  logic             sw_wr_en,
    input  logic [IDX_W-1:0] sw_wr_idx,
    input  logic             close,
    output logic [IDX_W-1:0] fill_idx,
    output logic             avail,
    output logic             wr_err
);
    logic [IDX_W-1:0] wr_q;
    logic [IDX_W-1:0] fill_q;
    logic             err_q;
    logic             aligned;

    assign aligned = (sw_wr_idx[2:0] == 3'b000);

    // Index and error-flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q   <= '0;
            fill_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (sw_wr_en && aligned)
                wr_q <= sw_wr_idx & mask;
            if (sw_wr_en && !aligned)
                err_q <= 1'b1;
            if (close)
                fill_q <= (fill_q + 1'b1) & mask;
        end
    end

    // A buffer is open when the fill index has not caught up with software.
    assign avail    = ((fill_q ^ wr_q) & mask) != '0;
    assign fill_idx = fill_q & mask;
    assign wr_err   = err_q;

    // R5: the fill index moves only while a buffer was available.
    assert_fill_stops_at_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q != $past(fill_q)) |-> $past(avail));

    // R4: a misaligned write leaves the write index alone and flags it.
    assert_misaligned_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_en && !aligned) |=> ($stable(wr_q) && err_q));

    // R4: the error flag is sticky.
    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
endmodule

// File: rtl/rxr_buf_acc.sv
// Module: byte accumulator for the open receive buffer.
// It adds accepted frame lengths and decides when the buffer closes,
// either on size or on timeout. Assumes open is the ring's availability.
module rxr_buf_acc #(
    parameter int LEN_W      = 14,
    parameter int UNIT_BYTES = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open,
    input  logic             frame_done,
    input  logic [LEN_W-1:0] frame_len,
    input  logic [1:0]       buf_size,
    input  logic             timeout_hit,
    output logic             take,
    output logic             close,
    output logic             holds_frame
);
    localparam int CAP_W = $clog2(4 * UNIT_BYTES) + 1;
    localparam int ACC_W = ((CAP_W > LEN_W) ? CAP_W : LEN_W) + 1;

    logic [ACC_W-1:0] bytes_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] cap;
    logic             holds_q;
    logic             size_full;

    // Capacity and the running total including a frame arriving now.
    always_comb begin
        cap       = ACC_W'(UNIT_BYTES) * (ACC_W'(buf_size) + 1'b1);
        take      = frame_done && open;
        sum       = bytes_q + ACC_W'(frame_len);
        size_full = take && (sum >= cap);
        close     = size_full || (timeout_hit && holds_q && open);
    end

    // Byte count and frame-present flag of the open buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bytes_q <= '0;
            holds_q <= 1'b0;
        end else if (close) begin
            bytes_q <= '0;
            holds_q <= 1'b0;
        end else if (take) begin
            bytes_q <= sum;
            holds_q <= 1'b1;
        end
    end

    assign holds_frame = holds_q;

    // R6: a size-driven close always includes an accepted frame.
    assert_size_close_has_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (close && !timeout_hit) |-> take);
endmodule

// File: rtl/rxr_close_timer.sv
// Module: idle timeout for a partially filled buffer.
// A prescaler divides the clock by TICK_DIV into ticks, and ticks are
// counted while the buffer holds data. Any accepted frame restarts it.
module rxr_close_timer #(
    parameter int TICK_DIV = 6400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       armed,
    input  logic       restart,
    input  logic [7:0] cfg_timeout,
    output logic       hit
);
    localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;

    logic [PW-1:0] presc_q;
    logic [7:0]    elapsed_q;
    logic          wrap;

    assign wrap = (presc_q == PW'(TICK_DIV - 1));

    // Prescaler and tick counter; held at zero while idle or on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed || restart) begin
            presc_q   <= '0;
            elapsed_q <= '0;
        end else begin
            presc_q <= wrap ? '0 : presc_q + 1'b1;
            if (wrap && elapsed_q != 8'hFF)
                elapsed_q <= elapsed_q + 1'b1;
        end
    end

    assign hit = armed && (cfg_timeout != 8'd0) && (elapsed_q == cfg_timeout);

    // R8: a tick is counted only when the prescaler had completed a period.
    assert_tick_on_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (elapsed_q != $past(elapsed_q) && elapsed_q != 8'd0) |-> $past(wrap));
endmodule

// File: rtl/rx_ring_tracker.sv
// Module: top of the receive descriptor ring index tracker.
// It joins the index control, the buffer accumulator and the close timer,
// and registers the status word and interrupt pulse on each buffer close.
module rx_ring_tracker
    import rxr_pkg::*;
#(
    parameter int TICK_DIV   = 6400,
    parameter int UNIT_BYTES = 4096,
    parameter int LEN_W      = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       cfg_ring_log2,
    input  logic [1:0]       cfg_buf_size,
    input  logic [7:0]       cfg_timeout,
    input  logic [1:0]       cfg_irq_dest,
    input  logic             sw_wr_en,
    input  logic [IDX_W-1:0] sw_wr_idx,
    input  logic             frame_done,
    input  logic [LEN_W-1:0] frame_len,
    output logic             buf_avail,
    output logic [31:0]      status_word,
    output logic             irq,
    output logic             wr_idx_err
);
    localparam logic [1:0] DEST_HOST = 2'b01;

    logic [IDX_W-1:0] mask;
    logic [IDX_W-1:0] fill_idx;
    logic             avail;
    logic             take;
    logic             close;
    logic             holds_frame;
    logic             timeout_hit;
    logic [IDX_W-1:0] status_q;
    logic             irq_q;

    assign mask = ring_mask(cfg_ring_log2);

    rxr_index_ctl u_index (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask      (mask),
        .sw_wr_en  (sw_wr_en),
        .sw_wr_idx (sw_wr_idx),
        .close     (close),
        .fill_idx  (fill_idx),
        .avail     (avail),
        .wr_err    (wr_idx_err)
    );

    rxr_buf_acc #(
        .LEN_W      (LEN_W),
        .UNIT_BYTES (UNIT_BYTES)
    ) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .open        (avail),
        .frame_done  (frame_done),
        .frame_len   (frame_len),
        .buf_size    (cfg_buf_size),
        .timeout_hit (timeout_hit),
        .take        (take),
        .close       (close),
        .holds_frame (holds_frame)
    );

    rxr_close_timer #(
        .TICK_DIV (TICK_DIV)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .armed       (holds_frame),
        .restart     (take),
        .cfg_timeout (cfg_timeout),
        .hit         (timeout_hit)
    );

    // Publish the closed index and pulse the interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= close && (cfg_irq_dest == DEST_HOST);
            if (close)
                status_q <= fill_idx;
        end
    end

    assign buf_avail   = avail;
    assign status_word = {{(32 - IDX_W){1'b0}}, status_q};
    assign irq         = irq_q;

    // R10: the interrupt fires only with the host destination selected.
    assert_irq_dest_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(cfg_irq_dest) == DEST_HOST);

    // R5: a frame arriving with no buffer available leaves the status alone.
    assert_drop_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !avail) |=> $stable(status_word));

    // R7: a close empties the buffer for the next descriptor.
    assert_close_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        close |=> !holds_frame);
endmodule

// File: tb/test_rx_ring_tracker.sv
`timescale 1ns/1ps
module test_rx_ring_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_ring_log2 = 4'd5;
    logic [1:0]  cfg_buf_size = 2'd0;
    logic [7:0]  cfg_timeout = 8'd0;
    logic [1:0]  cfg_irq_dest = 2'b01;
    logic        sw_wr_en = 1'b0;
    logic [11:0] sw_wr_idx = '0;
    logic        frame_done = 1'b0;
    logic [13:0] frame_len = '0;
    logic        buf_avail;
    logic [31:0] status_word;
    logic        irq;
    logic        wr_idx_err;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rx_ring_tracker #(.TICK_DIV(4), .UNIT_BYTES(64), .LEN_W(14)) i_rx_ring_tracker (
        .clk(clk), .rst_n(rst_n), .cfg_ring_log2(cfg_ring_log2),
        .cfg_buf_size(cfg_buf_size), .cfg_timeout(cfg_timeout),
        .cfg_irq_dest(cfg_irq_dest), .sw_wr_en(sw_wr_en), .sw_wr_idx(sw_wr_idx),
        .frame_done(frame_done), .frame_len(frame_len), .buf_avail(buf_avail),
        .status_word(status_word), .irq(irq), .wr_idx_err(wr_idx_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic sw_write(input logic [11:0] idx);
        sw_wr_en = 1'b1; sw_wr_idx = idx;
        @(negedge clk);
        sw_wr_en = 1'b0;
    endtask

    task automatic send_frame(input int len);
        frame_done = 1'b1; frame_len = 14'(len);
        @(negedge clk);
        frame_done = 1'b0;
    endtask

    task automatic wait_irq(input int max, output int cnt);
        cnt = 0;
        for (int c = 1; c <= max; c++) begin
            @(negedge clk);
            if (irq) begin cnt = c; break; end
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 status", status_word, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 err", {31'b0, wr_idx_err}, 0);
        chk("R1 avail", {31'b0, buf_avail}, 0);
    endtask

    task automatic t_fill_by_size;
        cfg_ring_log2 = 4'd5; cfg_buf_size = 2'd0;
        sw_write(12'd8);
        chk("R3 avail after write 8", {31'b0, buf_avail}, 1);
        for (int i = 0; i < 8; i++) begin
            send_frame(40);
            chk("R6 no close below size", {31'b0, irq}, 0);
            send_frame(30);
            chk("R10 irq on close", {31'b0, irq}, 1);
            chk("R7 status index", status_word, 32'(i));
        end
        @(negedge clk);
        chk("R10 irq single cycle", {31'b0, irq}, 0);
        chk("R5 full at wr index", {31'b0, buf_avail}, 0);
        send_frame(100);
        chk("R5 dropped frame irq", {31'b0, irq}, 0);
        chk("R5 dropped frame status", status_word, 7);
    endtask

    task automatic t_misaligned;
        sw_write(12'd13);
        chk("R4 err set", {31'b0, wr_idx_err}, 1);
        chk("R4 write ignored", {31'b0, buf_avail}, 0);
        sw_write(12'd16);
        chk("R4 err sticky", {31'b0, wr_idx_err}, 1);
        chk("R3 aligned accepted", {31'b0, buf_avail}, 1);
    endtask

    task automatic t_wrap;
        cfg_buf_size = 2'd1;
        send_frame(100);
        chk("R6 code 1 holds 100 bytes", {31'b0, irq}, 0);
        send_frame(30);
        chk("R6 code 1 closes at 128", status_word, 8);
        cfg_buf_size = 2'd0;
        for (int i = 9; i < 16; i++) send_frame(64);
        chk("R7 status 15", status_word, 15);
        sw_write(12'd24);
        for (int i = 16; i < 24; i++) send_frame(64);
        chk("R7 status 23", status_word, 23);
        sw_write(12'd0);
        chk("R2 wrapped write opens ring", {31'b0, buf_avail}, 1);
        for (int i = 24; i < 32; i++) send_frame(64);
        chk("R2 top index 31", status_word, 31);
        chk("R2 fill wraps to 0 full", {31'b0, buf_avail}, 0);
        sw_write(12'd8);
        send_frame(64);
        chk("R2 index 0 after wrap", status_word, 0);
    endtask

    task automatic t_timeout;
        int cnt;
        cfg_timeout = 8'd3;
        send_frame(10);
        wait_irq(40, cnt);
        chk("R8 close after T*DIV+1", 32'(cnt), 13);
        chk("R8 timeout status", status_word, 1);
    endtask

    task automatic t_restart;
        int cnt;
        int early;
        early = 0;
        send_frame(10);
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (irq) early++;
        end
        chk("R9 no early close", 32'(early), 0);
        send_frame(10);
        wait_irq(40, cnt);
        chk("R9 timer restarted", 32'(cnt), 13);
        chk("R9 status", status_word, 2);
    endtask

    task automatic t_disabled;
        int early;
        early = 0;
        cfg_timeout = 8'd0;
        send_frame(10);
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (irq) early++;
        end
        chk("R8 zero disables", 32'(early), 0);
        chk("R8 status held", status_word, 2);
        send_frame(60);
        chk("R6 earlier bytes kept", status_word, 3);
    endtask

    task automatic t_irq_dest;
        cfg_irq_dest = 2'b00;
        send_frame(64);
        chk("R10 dest 00 no irq", {31'b0, irq}, 0);
        chk("R7 close without irq", status_word, 4);
        cfg_irq_dest = 2'b01;
        send_frame(64);
        chk("R10 dest 01 irq", {31'b0, irq}, 1);
        chk("R7 status 5", status_word, 5);
    endtask

    task automatic t_clamp;
        t_reset();
        cfg_ring_log2 = 4'd2;
        sw_write(12'd32);
        chk("R2 exponent clamped to 5", {31'b0, buf_avail}, 0);
        cfg_ring_log2 = 4'd6;
        sw_write(12'd32);
        chk("R2 depth 64 keeps 32", {31'b0, buf_avail}, 1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_fill_by_size();
        t_misaligned();
        t_wrap();
        t_timeout();
        t_restart();
        t_disabled();
        t_irq_dest();
        t_clamp();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule